// File: doc/BRIEF.md
# Partition Protection Map Loader

This block is a small bus master on the host side of a battery-backed asynchronous SRAM that supports per-region write protection. The memory splits its space into sixteen equal regions, and a 16-bit map marks each region as protected (1) or writable (0). The memory only accepts a new map after it sees a fixed run of read cycles on its four top address bits. The loader runs that whole script on its own: twenty unlock reads, then four payload reads that carry the map four bits at a time.

The host places the wanted map on `mask_i` and pulses `start_i`. From then until the sequence finishes, the loader owns the memory bus. Every cycle it drives is a read. Write enable stays inactive, output enable stays active, and chip enable pulses once per read. Each phase of a read lasts a whole number of clock cycles. These counts are rounded up from nanosecond minimums for the configured clock period.

Data returned by the memory is never looked at. When the script ends, the loader releases the bus and raises a one-cycle `done_o`. An `abort_i` input ends the script early with every strobe inactive. Because no write reaches the memory, the memory keeps its previous map after an abort.

Top module: `prot_map_loader`

## Requirements
- R1: Out of reset and whenever idle, `mem_ce_n_o`, `mem_oe_n_o` and `mem_we_n_o` are all 1, `mem_addr_en_o` is 0, `mem_addr_o` is all zero, and `busy_o` and `done_o` are 0.
- R2: A `start_i` pulse while idle (and without `abort_i`) launches exactly 24 chip-enable low pulses. During the whole run `mem_we_n_o` stays 1. `mem_oe_n_o` is 0 and `mem_addr_en_o` is 1 in every cycle where `mem_ce_n_o` is 0.
- R3: Reads 1 to 20 drive the nibble `mem_addr_o[18:15]` with, in order, hex F, E, 7, 7, 3, 9, C, E, 7, 3, 9, 4, 2, 4, A, 6, 9, 1, 0, 5. Nibble bit 0 is address bit 15 and nibble bit 3 is address bit 18.
- R4: Read 21+k (k = 0..3) drives `mask_i[4k+3:4k]` on `mem_addr_o[18:15]`, with mask bit 4k on address bit 15. The mask is captured at start, and later changes of `mask_i` have no effect on the run.
- R5: While `mem_addr_en_o` is 1, `mem_addr_o[14:0]` is zero. The address for a read is valid and unchanged from at least one cycle before chip enable falls until chip enable rises again.
- R6: Chip enable stays low for exactly LOW_CYC cycles per read. LOW_CYC is the larger of ceil(75 ns / period) and ceil(50 ns / period), which is 8 at 10 ns. Between reads chip enable stays high for at least RECOV_CYC = ceil(10 ns / period) cycles (1 at 10 ns). Each read lasts SETUP_CYC + LOW_CYC + RECOV_CYC cycles, so `busy_o` is high for exactly 240 cycles at the defaults.
- R7: `done_o` is high for exactly one cycle per completed run. That cycle is the first cycle after the last read's recovery, with `busy_o` already 0.
- R8: A `start_i` pulse while busy is ignored. The run neither restarts nor lengthens, and it does not take up the new mask.
- R9: `abort_i` returns the loader to idle in the next cycle with the R1 output values and no `done_o`. The next start begins again at the first unlock read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse to begin a programming run |
| abort_i | input | 1 | Abandon the run and return to idle |
| mask_i | input | 16 | Region protection map, bit n protects region n |
| mem_addr_o | output | ADDR_W (19) | Memory address bus |
| mem_addr_en_o | output | 1 | Address bus drive enable, 0 means released |
| mem_ce_n_o | output | 1 | Memory chip enable, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_we_n_o | output | 1 | Memory write enable, active low, held inactive |
| busy_o | output | 1 | Run in progress, bus owned |
| done_o | output | 1 | One-cycle pulse after the 24th read |

## Verification
The bench records the address nibble at every chip-enable falling edge and compares all 24 against the script. It does this for an all-zero map, an all-ones map and a mixed map. A swapped nibble order or a reversed bit order inside a payload read would then show up as a wrong captured value. It also measures the low width and the high gap of every pulse, as well as the exact busy length. A phase counter that is off by one would shorten chip enable below the memory's minimum, or stretch the run, and both are caught.

A second start with a different mask is sent mid-run. A design that restarted or re-sampled the mask would give more than 24 pulses or the wrong payload. An abort mid-run must drop every strobe in the next cycle with no done pulse. The run that follows must begin again at hex F. A loader that kept its step count would resume partway through the script and never unlock the memory.

// File: rtl/pml_pkg.sv
package pml_pkg;

    localparam int NIB_W         = 4;
    localparam int MASK_W        = 16;
    localparam int UNLOCK_STEPS  = 20;
    localparam int PAYLOAD_STEPS = MASK_W / NIB_W;
    localparam int TOTAL_STEPS   = UNLOCK_STEPS + PAYLOAD_STEPS;
    localparam int STEP_W        = $clog2(TOTAL_STEPS);

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_LOW   = 2'd2,
        PH_RECOV = 2'd3
    } phase_e;

    // Unlock nibble for one step; bit 0 lands on the lowest field address bit.
    function automatic logic [NIB_W-1:0] unlock_nibble(input logic [STEP_W-1:0] idx);
        logic [NIB_W-1:0] v;
        case (idx)
            5'd0:    v = 4'hF;
            5'd1:    v = 4'hE;
            5'd2:    v = 4'h7;
            5'd3:    v = 4'h7;
            5'd4:    v = 4'h3;
            5'd5:    v = 4'h9;
            5'd6:    v = 4'hC;
            5'd7:    v = 4'hE;
            5'd8:    v = 4'h7;
            5'd9:    v = 4'h3;
            5'd10:   v = 4'h9;
            5'd11:   v = 4'h4;
            5'd12:   v = 4'h2;
            5'd13:   v = 4'h4;
            5'd14:   v = 4'hA;
            5'd15:   v = 4'h6;
            5'd16:   v = 4'h9;
            5'd17:   v = 4'h1;
            5'd18:   v = 4'h0;
            5'd19:   v = 4'h5;
            default: v = 4'h0;
        endcase
        return v;
    endfunction

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

endpackage

// File: rtl/pml_step_script.sv
module pml_step_script
    import pml_pkg::*;
(
    input  logic [STEP_W-1:0] step_i,
    input  logic [MASK_W-1:0] mask_i,
    output logic [NIB_W-1:0]  nib_o
);

    localparam int PIDX_W = $clog2(PAYLOAD_STEPS);

    logic [NIB_W-1:0]  payload [PAYLOAD_STEPS];
    logic [PIDX_W-1:0] pidx;

    // Slice the mask into one nibble per payload read, lowest bits first.
    for (genvar g = 0; g < PAYLOAD_STEPS; g++) begin : g_slice
        assign payload[g] = mask_i[g*NIB_W +: NIB_W];
    end

    assign pidx = PIDX_W'(step_i - STEP_W'(UNLOCK_STEPS));

    always_comb begin
        if (step_i < STEP_W'(UNLOCK_STEPS)) begin
            nib_o = unlock_nibble(step_i);
        end else begin
            nib_o = payload[pidx];
        end
    end

endmodule

// File: rtl/pml_addr_map.sv
module pml_addr_map
    import pml_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int FIELD_LSB = 15
) (
    input  logic [NIB_W-1:0]  nib_i,
    input  logic              en_i,
    output logic [ADDR_W-1:0] addr_o
);

    // Place the nibble on the field bits; every other bit stays zero.
    for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
        if (b >= FIELD_LSB && b < FIELD_LSB + NIB_W) begin : g_field
            assign addr_o[b] = en_i & nib_i[b-FIELD_LSB];
        end else begin : g_zero
            assign addr_o[b] = 1'b0;
        end
    end

endmodule

// File: rtl/prot_map_loader.sv
module prot_map_loader
    import pml_pkg::*;
#(
    parameter int ADDR_W        = 19,
    parameter int FIELD_LSB     = 15,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_SETUP_NS    = 0,
    parameter int T_HOLD_NS     = 50,
    parameter int T_CE_LOW_NS   = 75,
    parameter int T_RECOV_NS    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic [MASK_W-1:0] mask_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_addr_en_o,
    output logic              mem_ce_n_o,
    output logic              mem_oe_n_o,
    output logic              mem_we_n_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int SETUP_CYC = at_least_one(ceil_div(T_SETUP_NS, CLK_PERIOD_NS));
    localparam int WIDE_CYC  = at_least_one(ceil_div(T_CE_LOW_NS, CLK_PERIOD_NS));
    localparam int HOLD_CYC  = at_least_one(ceil_div(T_HOLD_NS, CLK_PERIOD_NS));
    localparam int LOW_CYC   = (WIDE_CYC > HOLD_CYC) ? WIDE_CYC : HOLD_CYC;
    localparam int RECOV_CYC = at_least_one(ceil_div(T_RECOV_NS, CLK_PERIOD_NS));
    localparam int MAX_A     = (SETUP_CYC > LOW_CYC) ? SETUP_CYC : LOW_CYC;
    localparam int MAX_CYC   = (MAX_A > RECOV_CYC) ? MAX_A : RECOV_CYC;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0]  SETUP_END = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0]  LOW_END   = CNT_W'(LOW_CYC - 1);
    localparam logic [CNT_W-1:0]  RECOV_END = CNT_W'(RECOV_CYC - 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(TOTAL_STEPS - 1);

    typedef struct packed {
        phase_e            phase;
        logic [STEP_W-1:0] step;
        logic [CNT_W-1:0]  cnt;
        logic [MASK_W-1:0] mask;
        logic [NIB_W-1:0]  nib;
        logic              drive;
        logic              ce_n;
        logic              oe_n;
        logic              done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [STEP_W-1:0] step_sel;
    logic [MASK_W-1:0] mask_sel;
    logic [NIB_W-1:0]  nib_next;

    // Step and mask whose nibble is needed for the next setup phase.
    always_comb begin
        if (seq_q.phase == PH_IDLE) begin
            step_sel = '0;
            mask_sel = mask_i;
        end else begin
            step_sel = seq_q.step + STEP_W'(1);
            mask_sel = seq_q.mask;
        end
    end

    pml_step_script u_script (
        .step_i (step_sel),
        .mask_i (mask_sel),
        .nib_o  (nib_next)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        if (abort_i) begin
            seq_d.phase = PH_IDLE;
            seq_d.step  = '0;
            seq_d.cnt   = '0;
            seq_d.nib   = '0;
            seq_d.drive = 1'b0;
            seq_d.ce_n  = 1'b1;
            seq_d.oe_n  = 1'b1;
        end else begin
            case (seq_q.phase)
                PH_IDLE: begin
                    if (start_i) begin
                        seq_d.phase = PH_SETUP;
                        seq_d.step  = '0;
                        seq_d.cnt   = '0;
                        seq_d.mask  = mask_i;
                        seq_d.nib   = nib_next;
                        seq_d.drive = 1'b1;
                        seq_d.ce_n  = 1'b1;
                        seq_d.oe_n  = 1'b0;
                    end
                end
                PH_SETUP: begin
                    if (seq_q.cnt == SETUP_END) begin
                        seq_d.phase = PH_LOW;
                        seq_d.cnt   = '0;
                        seq_d.ce_n  = 1'b0;
                    end else begin
                        seq_d.cnt = seq_q.cnt + CNT_W'(1);
                    end
                end
                PH_LOW: begin
                    if (seq_q.cnt == LOW_END) begin
                        seq_d.phase = PH_RECOV;
                        seq_d.cnt   = '0;
                        seq_d.ce_n  = 1'b1;
                    end else begin
                        seq_d.cnt = seq_q.cnt + CNT_W'(1);
                    end
                end
                PH_RECOV: begin
                    if (seq_q.cnt != RECOV_END) begin
                        seq_d.cnt = seq_q.cnt + CNT_W'(1);
                    end else if (seq_q.step == LAST_STEP) begin
                        seq_d.phase = PH_IDLE;
                        seq_d.step  = '0;
                        seq_d.cnt   = '0;
                        seq_d.nib   = '0;
                        seq_d.drive = 1'b0;
                        seq_d.oe_n  = 1'b1;
                        seq_d.done  = 1'b1;
                    end else begin
                        seq_d.phase = PH_SETUP;
                        seq_d.step  = step_sel;
                        seq_d.cnt   = '0;
                        seq_d.nib   = nib_next;
                    end
                end
                default: seq_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.phase <= PH_IDLE;
            seq_q.ce_n  <= 1'b1;
            seq_q.oe_n  <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    pml_addr_map #(
        .ADDR_W    (ADDR_W),
        .FIELD_LSB (FIELD_LSB)
    ) u_addr (
        .nib_i  (seq_q.nib),
        .en_i   (seq_q.drive),
        .addr_o (mem_addr_o)
    );

    assign mem_addr_en_o = seq_q.drive;
    assign mem_ce_n_o    = seq_q.ce_n;
    assign mem_oe_n_o    = seq_q.oe_n;
    assign mem_we_n_o    = 1'b1;
    assign busy_o        = (seq_q.phase != PH_IDLE);
    assign done_o        = seq_q.done;

endmodule

// File: rtl/pml_checker.sv
module pml_checker #(
    parameter int ADDR_W    = 19,
    parameter int FIELD_LSB = 15,
    parameter int LOW_CYC   = 8,
    parameter int RECOV_CYC = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_addr_en_o,
    input logic              mem_ce_n_o,
    input logic              mem_oe_n_o,
    input logic              mem_we_n_o,
    input logic              busy_o,
    input logic              done_o
);

    localparam int RUN_W = 16;

    logic              prev_ce_n;
    logic              prev_done;
    logic [ADDR_W-1:0] prev_addr;
    logic [RUN_W-1:0]  low_run;
    logic [RUN_W-1:0]  high_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_ce_n <= 1'b1;
            prev_done <= 1'b0;
            prev_addr <= '0;
            low_run   <= '0;
            high_run  <= '0;
        end else begin
            prev_ce_n <= mem_ce_n_o;
            prev_done <= done_o;
            prev_addr <= mem_addr_o;
            if (mem_ce_n_o) begin
                low_run  <= '0;
                high_run <= (&high_run) ? high_run : high_run + RUN_W'(1);
            end else begin
                high_run <= '0;
                low_run  <= (&low_run) ? low_run : low_run + RUN_W'(1);
            end
        end
    end

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (mem_ce_n_o && mem_oe_n_o && mem_we_n_o && !mem_addr_en_o)); // R1

    AST_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n_o |-> (mem_we_n_o && !mem_oe_n_o && mem_addr_en_o && busy_o)); // R2

    AST_LOWER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr_en_o |-> (mem_addr_o[FIELD_LSB-1:0] == '0)); // R5

    AST_ADDR_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n_o && prev_ce_n) |-> (mem_addr_o == prev_addr)); // R5

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n_o && !prev_ce_n) |-> (mem_addr_o == prev_addr)); // R5

    AST_CE_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ce_n_o && !prev_ce_n && busy_o) |-> (32'(low_run) == LOW_CYC)); // R6

    AST_CE_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n_o && prev_ce_n) |-> (32'(high_run) >= RECOV_CYC)); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !prev_done)); // R7

endmodule

bind prot_map_loader pml_checker #(
    .ADDR_W    (ADDR_W),
    .FIELD_LSB (FIELD_LSB),
    .LOW_CYC   (LOW_CYC),
    .RECOV_CYC (RECOV_CYC)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_addr_o    (mem_addr_o),
    .mem_addr_en_o (mem_addr_en_o),
    .mem_ce_n_o    (mem_ce_n_o),
    .mem_oe_n_o    (mem_oe_n_o),
    .mem_we_n_o    (mem_we_n_o),
    .busy_o        (busy_o),
    .done_o        (done_o)
);

// File: tb/sim_prot_map_loader.sv
`timescale 1ns/1ps
module sim_prot_map_loader;

    localparam int AW       = 19;
    localparam int EXP_LOW  = 8;    // max(ceil(75/10), ceil(50/10))
    localparam int EXP_REC  = 1;    // ceil(10/10)
    localparam int EXP_BUSY = 24 * (1 + 8 + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          abort_i = 1'b0;
    logic [15:0]   mask_i = '0;
    logic [AW-1:0] mem_addr_o;
    logic          mem_addr_en_o, mem_ce_n_o, mem_oe_n_o, mem_we_n_o;
    logic          busy_o, done_o;

    always #5 clk = ~clk;

    prot_map_loader #(
        .ADDR_W(AW), .FIELD_LSB(15), .CLK_PERIOD_NS(10),
        .T_SETUP_NS(0), .T_HOLD_NS(50), .T_CE_LOW_NS(75), .T_RECOV_NS(10)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
        .mask_i(mask_i), .mem_addr_o(mem_addr_o), .mem_addr_en_o(mem_addr_en_o),
        .mem_ce_n_o(mem_ce_n_o), .mem_oe_n_o(mem_oe_n_o), .mem_we_n_o(mem_we_n_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    int checks = 0;
    int fails  = 0;

    logic [3:0] unl [20] = '{4'hF, 4'hE, 4'h7, 4'h7, 4'h3, 4'h9, 4'hC, 4'hE, 4'h7, 4'h3,
                             4'h9, 4'h4, 4'h2, 4'h4, 4'hA, 4'h6, 4'h9, 4'h1, 4'h0, 4'h5};

    // Bus monitor, sampled on falling clock edges.
    logic          prev_ce;
    logic [AW-1:0] prev_addr;
    logic [3:0]    cap [32];
    int nfall, low_run, high_run, min_low, max_low, min_high;
    int busy_cnt, done_cnt, we_bad, oe_bad, low_bits_bad, addr_bad;

    task automatic mon_clear();
        nfall = 0; low_run = 0; high_run = 1000; min_low = 1000; max_low = 0;
        min_high = 1000; busy_cnt = 0; done_cnt = 0; we_bad = 0; oe_bad = 0;
        low_bits_bad = 0; addr_bad = 0; prev_ce = 1'b1; prev_addr = '0;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy_o) busy_cnt++;
            if (done_o) done_cnt++;
            if (!mem_we_n_o) we_bad++;
            if (mem_addr_en_o && mem_addr_o[14:0] != 15'd0) low_bits_bad++;
            if (!mem_ce_n_o) begin
                if (mem_oe_n_o || !mem_addr_en_o) oe_bad++;
                if (mem_addr_o != prev_addr) addr_bad++;
                if (prev_ce) begin
                    if (nfall < 32) cap[nfall] = mem_addr_o[18:15];
                    nfall++;
                    if (high_run < min_high) min_high = high_run;
                end
                low_run++;
                high_run = 0;
            end else begin
                if (!prev_ce && busy_o) begin
                    if (low_run < min_low) min_low = low_run;
                    if (low_run > max_low) max_low = low_run;
                end
                low_run = 0;
                high_run++;
            end
            prev_ce   = mem_ce_n_o;
            prev_addr = mem_addr_o;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [15:0] m);
        @(negedge clk);
        mask_i  = m;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 600 && done_cnt == 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_script(input logic [15:0] m, input string tag);
        chk(nfall == 24, "R2", {tag, " read count"}, nfall, 24);
        for (int i = 0; i < 20; i++)
            chk(cap[i] == unl[i], "R3", {tag, " unlock nibble"}, cap[i], unl[i]);
        for (int k = 0; k < 4; k++)
            chk(cap[20+k] == m[4*k +: 4], "R4", {tag, " payload nibble"},
                cap[20+k], m[4*k +: 4]);
    endtask

    task automatic check_timing(input string tag);
        chk(we_bad == 0, "R2", {tag, " write enable low"}, we_bad, 0);
        chk(oe_bad == 0, "R2", {tag, " oe/addr during read"}, oe_bad, 0);
        chk(low_bits_bad == 0, "R5", {tag, " lower address bits"}, low_bits_bad, 0);
        chk(addr_bad == 0, "R5", {tag, " address moved around ce low"}, addr_bad, 0);
        chk(min_low == EXP_LOW && max_low == EXP_LOW, "R6", {tag, " ce low width"},
            min_low, EXP_LOW);
        chk(min_high >= EXP_REC, "R6", {tag, " ce recovery"}, min_high, EXP_REC);
        chk(busy_cnt == EXP_BUSY, "R6", {tag, " busy length"}, busy_cnt, EXP_BUSY);
        chk(done_cnt == 1, "R7", {tag, " done cycles"}, done_cnt, 1);
    endtask

    task automatic check_idle(input string req, input string tag);
        chk(mem_ce_n_o && mem_oe_n_o && mem_we_n_o, req, {tag, " strobes high"},
            {mem_ce_n_o, mem_oe_n_o, mem_we_n_o}, 3'b111);
        chk(!mem_addr_en_o && mem_addr_o == '0, req, {tag, " bus released"},
            mem_addr_o, 0);
        chk(!busy_o, req, {tag, " busy"}, busy_o, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check_idle("R1", "reset");
        chk(!done_o, "R1", "reset done", done_o, 0);
    endtask

    task automatic t_run(input logic [15:0] m, input string tag);
        mon_clear();
        pulse_start(m);
        wait_done();
        check_script(m, tag);
        check_timing(tag);
        check_idle("R1", {tag, " after run"});
    endtask

    task automatic t_start_busy();
        mon_clear();
        pulse_start(16'h3C96);
        repeat (37) @(negedge clk);
        mask_i  = 16'hFFFF;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (60) @(negedge clk);
        mask_i = 16'h0000;
        wait_done();
        check_script(16'h3C96, "R8 restart ignored");
        chk(busy_cnt == EXP_BUSY, "R8", "busy length with second start",
            busy_cnt, EXP_BUSY);
        chk(done_cnt == 1, "R8", "single done", done_cnt, 1);
    endtask

    task automatic t_abort();
        int seen;
        mon_clear();
        pulse_start(16'h1234);
        repeat (55) @(negedge clk);
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        check_idle("R9", "abort next cycle");
        seen = nfall;
        chk(seen > 0 && seen < 24, "R9", "reads before abort", seen, 6);
        repeat (300) @(negedge clk);
        chk(done_cnt == 0, "R9", "no done after abort", done_cnt, 0);
        chk(nfall == seen, "R9", "no reads after abort", nfall, seen);
        t_run(16'h8001, "R9 rerun");
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        mon_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_run(16'h0000, "all clear");
        t_run(16'hFFFF, "all set");
        t_run(16'hA5C3, "mixed");
        t_start_busy();
        t_abort();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule